// File: doc/BRIEF.md
# BIST Receive Pattern Checker

This block sits at the output of a receive deserializer and checks a stream of 8-bit characters against a pseudo-random self-test pattern that it produces on its own. Once software sets the check-enable bit and the receive PLL reports lock, the checker searches the incoming characters for the pattern's marker character. When it finds the marker it locks onto the sequence and compares every later valid character against its own copy of the pattern.

The result of each comparison appears as a registered 3-bit status code and a one-cycle match or error pulse. A one-cycle end flag marks the last character of each complete sequence, after which checking runs on into the next sequence without a new search. The checker keeps a signed count of errors minus matches. When errors pull ahead of matches by more than a set limit, it gives up on the current alignment and searches for the marker again. If lock is lost, it returns to its start state from whatever state it is in.

Top module: `bist_rx_checker`

## Requirements
- R1: Reset clears the check-enable bit. While the bit is clear, the status reads 111, no match, error or end pulse is produced, and valid characters have no effect.
- R2: A cycle with cfg_we high loads cfg_en into the enable bit. Two clock edges after a write of 1 (made while disabled), the status reads 000.
- R3: While enabled, pll_lock low at a clock edge makes the status 000 after that edge, whatever the previous state.
- R4: The pattern comes from a 9-bit register s with seed 9'h1FF, stepped as s_next = {s[7:0], s[8]^s[4]}. Character k of the sequence is s[7:0] after k steps, for k = 0 to 510. The sequence repeats every 511 characters, and its first character 8'hFF is the marker.
- R5: In search (status 000 or 001), a valid character equal to the marker gives status 010 and a match pulse one edge later. Any other valid character gives status 001 and no pulse.
- R6: While locked to the sequence (status 010, 011 or 100), each valid character produces, one edge later, either a match pulse with status 010 (when it equals the expected character) or an error pulse with status 011 (when it does not). The two pulses never occur together.
- R7: A signed error-minus-match count goes up on each compared error and down on each compared match. It saturates at -64 and is cleared on marker sync and at sequence end. An error that takes the count above 16 gives status 001 (search) together with its error pulse.
- R8: The comparison of character 510 without overflow gives status 100 and a one-cycle seq_end pulse. The next character is compared against the marker without a new search.
- R9: In a cycle without rx_valid (while enabled and locked), the status holds and no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the enable bit |
| cfg_en | input | 1 | Value written to the enable bit |
| pll_lock | input | 1 | Receive PLL lock indicator |
| rx_valid | input | 1 | rx_char carries a character this cycle |
| rx_char | input | 8 | Received character |
| status | output | 3 | Checker state code (000 start, 001 search, 010 match, 011 error, 100 end, 111 off) |
| match_pulse | output | 1 | One-cycle pulse: last character matched |
| error_pulse | output | 1 | One-cycle pulse: last character mismatched |
| seq_end | output | 1 | One-cycle pulse: last character of a sequence was compared |

## Verification
The checker is driven with clean pattern runs, sparse single errors among matches, and a full sequence that ends on character 510. Together these separate correct pattern generation, the end flag and the wrap into the next sequence. An error burst sized so that the count reaches exactly 16 and then 17 pins the overflow threshold. A long match run followed by 80 errors keeps the checker locked only if the count saturates at -64, and a count that wraps instead of saturating would drop sync early. Junk characters in search, a mid-sequence lock drop, a disable write and a reset mid-run show that search ignores non-markers and that the forced states override everything else.

// File: rtl/bist_chk_pkg.sv
package bist_chk_pkg;

  typedef enum logic [2:0] {
    ST_START = 3'b000,
    ST_WAIT  = 3'b001,
    ST_MATCH = 3'b010,
    ST_ERROR = 3'b011,
    ST_END   = 3'b100,
    ST_OFF   = 3'b111
  } bist_st_e;

endpackage

// File: rtl/bist_pat_gen.sv
module bist_pat_gen #(
  parameter int LFSR_W = 9,
  parameter int TAP    = 5,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_ld,
  input  logic              step,
  output logic [CHAR_W-1:0] exp_char,
  output logic [CHAR_W-1:0] marker,
  output logic              at_last
);

  localparam logic [LFSR_W-1:0] SEED     = '1;
  localparam logic [LFSR_W-1:0] LAST_IDX = {{(LFSR_W-1){1'b1}}, 1'b0};

  function automatic logic [LFSR_W-1:0] lfsr_nxt(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[LFSR_W-1] ^ s[TAP-1]};
  endfunction

  logic [LFSR_W-1:0] lfsr_q;
  logic [LFSR_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr_q <= SEED;
      idx_q  <= '0;
    end else if (sync_ld) begin
      lfsr_q <= lfsr_nxt(SEED);
      idx_q  <= LFSR_W'(1);
    end else if (step) begin
      if (idx_q == LAST_IDX) begin
        lfsr_q <= SEED;
        idx_q  <= '0;
      end else begin
        lfsr_q <= lfsr_nxt(lfsr_q);
        idx_q  <= idx_q + 1'b1;
      end
    end
  end

  assign exp_char = lfsr_q[CHAR_W-1:0];
  assign marker   = SEED[CHAR_W-1:0];
  assign at_last  = (idx_q == LAST_IDX);

  // R8: stepping past the last character returns the pattern to its marker
  p_wrap_marker_r8: assert property (@(posedge clk) disable iff (rst)
    (step && !sync_ld && at_last) |=> (exp_char == marker && idx_q == '0));

  // R4: a sync load leaves the generator one step past the marker
  p_sync_index_r4: assert property (@(posedge clk) disable iff (rst)
    sync_ld |=> (idx_q == LFSR_W'(1)));

endmodule

// File: rtl/bist_gap_cnt.sv
module bist_gap_cnt #(
  parameter int DIFF_W = 7,
  parameter int LIMIT  = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  input  logic dec,
  output logic ovf
);

  localparam logic signed [DIFF_W-1:0] DMIN = {1'b1, {(DIFF_W-1){1'b0}}};
  localparam logic signed [DIFF_W-1:0] DLIM = LIMIT[DIFF_W-1:0];

  logic signed [DIFF_W-1:0] diff_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      diff_q <= '0;
    end else if (inc) begin
      diff_q <= diff_q + 1'b1;
    end else if (dec && diff_q != DMIN) begin
      diff_q <= diff_q - 1'b1;
    end
  end

  assign ovf = inc && (diff_q >= DLIM);

  // R7: the count never wraps below its minimum
  p_sat_min_r7: assert property (@(posedge clk) disable iff (rst)
    (dec && !inc && !clr && diff_q == DMIN) |=> (diff_q == DMIN));

  // R7: the count stays within its legal range
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    (diff_q <= DLIM));

endmodule

// File: rtl/bist_rx_checker.sv
module bist_rx_checker
  import bist_chk_pkg::*;
#(
  parameter int CHAR_W    = 8,
  parameter int LFSR_W    = 9,
  parameter int LFSR_TAP  = 5,
  parameter int DIFF_W    = 7,
  parameter int ERR_LIMIT = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_en,
  input  logic              pll_lock,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_char,
  output logic [2:0]        status,
  output logic              match_pulse,
  output logic              error_pulse,
  output logic              seq_end
);

  logic              en_q;
  bist_st_e          st_q, st_d;
  logic              match_d, error_d, end_d;
  logic [CHAR_W-1:0] exp_char, marker;
  logic              at_last, ovf;
  logic              searching, comparing, run;
  logic              is_marker, hit;
  logic              pg_sync, pg_step;
  logic              gc_clr, gc_inc, gc_dec;

  // enable bit, cleared by reset
  always_ff @(posedge clk) begin
    if (rst)         en_q <= 1'b0;
    else if (cfg_we) en_q <= cfg_en;
  end

  assign searching = (st_q == ST_START) || (st_q == ST_WAIT);
  assign comparing = (st_q == ST_MATCH) || (st_q == ST_ERROR) || (st_q == ST_END);
  assign run       = en_q && pll_lock && rx_valid;
  assign is_marker = (rx_char == marker);
  assign hit       = (rx_char == exp_char);
  assign pg_sync   = run && searching && is_marker;
  assign pg_step   = run && comparing;
  assign gc_inc    = pg_step && !hit;
  assign gc_dec    = pg_step && hit;
  assign gc_clr    = !en_q || !pll_lock || pg_sync || (pg_step && (at_last || ovf));

  bist_pat_gen #(
    .LFSR_W (LFSR_W),
    .TAP    (LFSR_TAP),
    .CHAR_W (CHAR_W)
  ) u_pat (
    .clk      (clk),
    .rst      (rst),
    .sync_ld  (pg_sync),
    .step     (pg_step),
    .exp_char (exp_char),
    .marker   (marker),
    .at_last  (at_last)
  );

  bist_gap_cnt #(
    .DIFF_W (DIFF_W),
    .LIMIT  (ERR_LIMIT)
  ) u_gap (
    .clk (clk),
    .rst (rst),
    .clr (gc_clr),
    .inc (gc_inc),
    .dec (gc_dec),
    .ovf (ovf)
  );

  always_comb begin
    st_d    = st_q;
    match_d = 1'b0;
    error_d = 1'b0;
    end_d   = 1'b0;
    if (!en_q) begin
      st_d = ST_OFF;
    end else if (st_q == ST_OFF || !pll_lock) begin
      st_d = ST_START;
    end else if (rx_valid) begin
      if (searching) begin
        st_d    = is_marker ? ST_MATCH : ST_WAIT;
        match_d = is_marker;
      end else begin
        match_d = hit;
        error_d = !hit;
        if (ovf)          st_d = ST_WAIT;
        else if (at_last) begin
          st_d  = ST_END;
          end_d = 1'b1;
        end
        else if (hit)     st_d = ST_MATCH;
        else              st_d = ST_ERROR;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_OFF;
      match_pulse <= 1'b0;
      error_pulse <= 1'b0;
      seq_end     <= 1'b0;
    end else begin
      st_q        <= st_d;
      match_pulse <= match_d;
      error_pulse <= error_d;
      seq_end     <= end_d;
    end
  end

  assign status = st_q;

  // R1: a clear enable bit forces the off code and silences the pulses
  p_disabled_off_r1: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> (status == 3'b111 && !match_pulse && !error_pulse && !seq_end));

  // R3: lock loss forces the start state
  p_lock_loss_start_r3: assert property (@(posedge clk) disable iff (rst)
    (en_q && !pll_lock) |=> (status == 3'b000));

  // R6: match and error pulses are exclusive
  p_pulse_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(match_pulse && error_pulse));

  // R7: an overflowing error sends the checker back to search
  p_overflow_wait_r7: assert property (@(posedge clk) disable iff (rst)
    (pg_step && ovf) |=> (status == 3'b001 && error_pulse));

  // R8: the end flag only appears with the end code
  p_end_code_r8: assert property (@(posedge clk) disable iff (rst)
    seq_end |-> (status == 3'b100));

  // R9: an idle cycle holds the state
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (en_q && pll_lock && !rx_valid && st_q != ST_OFF) |=> ($stable(status) && !match_pulse && !error_pulse));

endmodule

// File: tb/bist_rx_checker_bench.sv
module bist_rx_checker_bench;

  localparam int OP_GOOD = 0;
  localparam int OP_BAD  = 1;
  localparam int OP_IDLE = 2;
  localparam int OP_JUNK = 3;
  localparam int OP_REST = 4;
  localparam int NVEC    = 16;

  typedef struct packed {
    logic [2:0]  op;
    logic [15:0] cnt;
    logic [2:0]  st;
    logic [15:0] nm;
    logic [15:0] ne;
    logic [3:0]  nend;
  } vec_t;

  function automatic vec_t mk(int op, int cnt, int st, int nm, int ne, int nend);
    vec_t v;
    v.op = 3'(op); v.cnt = 16'(cnt); v.st = 3'(st);
    v.nm = 16'(nm); v.ne = 16'(ne); v.nend = 4'(nend);
    return v;
  endfunction

  // op, count, expected status, matches, errors, end flags
  localparam vec_t VEC [NVEC] = '{
    mk(OP_GOOD,   1, 3'b010,   1,  0, 0),  // R5 marker sync
    mk(OP_GOOD,  99, 3'b010,  99,  0, 0),  // R4 R6 clean run
    mk(OP_BAD,    1, 3'b011,   0,  1, 0),  // R6 single error
    mk(OP_GOOD,  50, 3'b010,  50,  0, 0),
    mk(OP_BAD,   10, 3'b011,   0, 10, 0),  // R7 sparse errors keep sync
    mk(OP_GOOD, 350, 3'b100, 350,  0, 1),  // R8 sequence end
    mk(OP_GOOD,   1, 3'b010,   1,  0, 0),  // R8 marker compared without search
    mk(OP_BAD,   16, 3'b011,   0, 16, 0),
    mk(OP_BAD,    1, 3'b011,   0,  1, 0),  // R7 count exactly 16 keeps sync
    mk(OP_BAD,    1, 3'b001,   0,  1, 0),  // R7 count 17 drops sync
    mk(OP_JUNK,   5, 3'b001,   0,  0, 0),  // R5 non-marker in search
    mk(OP_REST,  20, 3'b010,  20,  0, 0),  // R5 resync on marker
    mk(OP_IDLE,  10, 3'b010,   0,  0, 0),  // R9 idle holds
    mk(OP_GOOD, 180, 3'b010, 180,  0, 0),
    mk(OP_BAD,   80, 3'b011,   0, 80, 0),  // R7 saturated count absorbs 80
    mk(OP_BAD,    1, 3'b001,   0,  1, 0)   // R7 then overflows
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0, cfg_en = 1'b0;
  logic       pll_lock = 1'b1;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_char = 8'h00;
  logic [2:0] status;
  logic       match_pulse, error_pulse, seq_end;

  int checks = 0, failures = 0;
  int cyc = 0;
  int tx_idx = 0;
  int cm, ce, cend;
  logic [7:0] pat [0:510];

  always #5 clk = ~clk;

  bist_rx_checker u_bist_rx_checker (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_en(cfg_en),
    .pll_lock(pll_lock), .rx_valid(rx_valid), .rx_char(rx_char),
    .status(status), .match_pulse(match_pulse), .error_pulse(error_pulse),
    .seq_end(seq_end)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // op: drive count cycles and tally the pulses seen
  task automatic run_seg(input int op, input int cnt);
    cm = 0; ce = 0; cend = 0;
    if (op == OP_REST) tx_idx = 0;
    for (int i = 0; i < cnt; i++) begin
      @(negedge clk);
      rx_valid = (op != OP_IDLE);
      case (op)
        OP_BAD:  rx_char = ~pat[tx_idx];
        OP_JUNK: rx_char = 8'h5A;
        OP_IDLE: rx_char = 8'h00;
        default: rx_char = pat[tx_idx];
      endcase
      if (op == OP_GOOD || op == OP_BAD || op == OP_REST)
        tx_idx = (tx_idx == 510) ? 0 : tx_idx + 1;
      @(posedge clk); #1;
      cm += int'(match_pulse); ce += int'(error_pulse); cend += int'(seq_end);
    end
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic cfg_write(input logic v);
    @(negedge clk); cfg_we = 1'b1; cfg_en = v;
    @(negedge clk); cfg_we = 1'b0;
    @(posedge clk); #1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [8:0] s = 9'h1FF;
    for (int k = 0; k < 511; k++) begin
      pat[k] = s[7:0];
      s = {s[7:0], s[8] ^ s[4]};
    end

    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    check("R1 reset status", int'(status), 3'b111);
    check("R1 reset pulses", int'({match_pulse, error_pulse, seq_end}), 0);

    cfg_write(1'b1);
    check("R2 enable gives start", int'(status), 3'b000);

    for (int v = 0; v < NVEC; v++) begin
      run_seg(int'(VEC[v].op), int'(VEC[v].cnt));
      check($sformatf("R6 vec%0d status", v), int'(status), int'(VEC[v].st));
      check($sformatf("R6 vec%0d matches", v), cm, int'(VEC[v].nm));
      check($sformatf("R6 vec%0d errors", v), ce, int'(VEC[v].ne));
      check($sformatf("R8 vec%0d ends", v), cend, int'(VEC[v].nend));
    end

    // R3: lock drop mid-sequence
    run_seg(OP_REST, 10);
    check("R3 locked before drop", int'(status), 3'b010);
    @(negedge clk); pll_lock = 1'b0;
    @(posedge clk); #1;
    check("R3 lock loss start", int'(status), 3'b000);
    @(negedge clk); pll_lock = 1'b1;
    run_seg(OP_JUNK, 1);
    check("R5 start to search", int'(status), 3'b001);
    run_seg(OP_REST, 1);
    check("R5 resync after lock", int'(status), 3'b010);
    check("R5 resync match pulse", cm, 1);

    // R1: disable ignores characters
    cfg_write(1'b0);
    check("R1 disabled status", int'(status), 3'b111);
    run_seg(OP_REST, 5);
    check("R1 disabled ignores status", int'(status), 3'b111);
    check("R1 disabled ignores pulses", cm + ce + cend, 0);

    // R1: reset clears an enabled checker
    cfg_write(1'b1);
    check("R2 re-enable start", int'(status), 3'b000);
    run_seg(OP_REST, 1);
    check("R5 sync before reset", int'(status), 3'b010);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    check("R1 reset clears enable", int'(status), 3'b111);
    run_seg(OP_REST, 3);
    check("R1 after reset still off", int'(status), 3'b111);
    check("R1 after reset no pulses", cm + ce + cend, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule